// File: doc/BRIEF.md
# Fetch-Side Branch Predictor with Call/Return Stack

This block sits beside the instruction fetch stage and guesses where fetch should go next. Each cycle the fetch stage presents the current fetch address together with a pre-decoded branch kind (jump, conditional, call or return) and, for conditionals, the decoded displacement target. The predictor answers in the same cycle with a taken flag and the next fetch address. Jumps, calls and conditionals are looked up in a small direct-mapped target buffer whose entries carry a tag, a stored target and a 2-bit saturating history. Returns are predicted only from a separate circular call/return stack. A conditional that misses in the buffer falls back to a static guess: backward taken, forward not taken.

The execute stage reports every resolved branch on a resolve port: its address, kind, real direction and target, plus the prediction that was made for it. The buffer is trained from this port: a hit updates the history and refreshes the target, and a taken branch that misses claims the indexed entry. When the real outcome differs from the prediction, the block raises a one-cycle redirect carrying the correct address. The redirect path is a two-state machine: QUIET moves to FIRE on a mispredicted resolve, FIRE moves back to QUIET unless another misprediction arrives in that cycle, and QUIET stays QUIET otherwise. The history per entry is a four-state machine: STRONG_NT, WEAK_NT, WEAK_T and STRONG_T. A taken resolve steps one state toward STRONG_T and a not-taken resolve steps one state toward STRONG_NT, saturating at both ends. A new entry starts in WEAK_T.

Top module: `bpred_top`

## Requirements
- R1: A jump (kind 0) or call (kind 2) whose address hits in the buffer is predicted taken to the stored target. On a miss it is predicted not taken. Whenever the prediction is not taken, the predicted address is the fetch address plus 4.
- R2: A conditional (kind 1) that hits is predicted taken to the stored target when its history is WEAK_T or STRONG_T (encodings 2 and 3), and not taken otherwise.
- R3: A conditional that misses is predicted taken to its decoded target when that target is below the fetch address, and not taken otherwise.
- R4: A fetched call with stack enable high pushes its address plus 4. A fetched return (kind 3) with a non-empty stack pops, and the popped value is the predicted target.
- R5: Resolved returns never allocate or modify a buffer entry.
- R6: With the buffer enable low, every fetch is predicted not taken to the address plus 4.
- R7: With the stack enable low, a return is not predicted, and neither calls nor returns change the stack.
- R8: A resolve whose direction differs from the prediction, or that is taken to a target different from the predicted target, raises redirect for exactly the next cycle. The redirect carries the real target if the branch was taken, and the branch address plus 4 if it was not. Otherwise redirect stays low.
- R9: A resolved conditional that hits steps its history by one state and saturates at both ends. A taken non-return branch that misses replaces the indexed entry, with the history set to WEAK_T. The index is address bits 5:2 and the tag is bits 31:6.
- R10: The stack holds 8 entries and wraps on overflow. After 9 pushes, 8 pops return the 8 newest values, newest first.
- R11: A return fetched with an empty stack is predicted not taken.
- R12: After reset the buffer is empty, the stack is empty and redirect is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btb_en | input | 1 | Buffer prediction enable |
| ras_en | input | 1 | Call/return stack enable |
| fetch_valid | input | 1 | A branch is being fetched this cycle |
| fetch_pc | input | 32 | Fetch address of the branch |
| fetch_kind | input | 2 | 0 jump, 1 conditional, 2 call, 3 return |
| fetch_static_tgt | input | 32 | Decoded target of a conditional |
| pred_taken | output | 1 | Prediction is taken |
| pred_target | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A branch is resolved this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_kind | input | 2 | Kind of the resolved branch |
| res_taken | input | 1 | Real direction |
| res_target | input | 32 | Real taken target |
| res_pred_taken | input | 1 | Direction that was predicted |
| res_pred_target | input | 32 | Target that was predicted |
| redirect | output | 1 | One-cycle misprediction redirect |
| redirect_pc | output | 32 | Correct fetch address during redirect |

## Verification
The assertions assume that the fetch kind is a legal 2-bit code on every valid cycle. They also assume that the resolve fields are stable and meaningful whenever res_valid is high, since the redirect target checks sample them one cycle back. The bench drives all inputs at the falling edge from a pool of addresses that share a few tags per index, so hits, aliasing replacements and stack wraps all occur. The enables are held high most of the time but are toggled often enough to exercise both gated paths.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        BR_JUMP = 2'd0,
        BR_COND = 2'd1,
        BR_CALL = 2'd2,
        BR_RET  = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        HIST_STRONG_NT = 2'd0,
        HIST_WEAK_NT   = 2'd1,
        HIST_WEAK_T    = 2'd2,
        HIST_STRONG_T  = 2'd3
    } hist_e;

    typedef enum logic {
        RDR_QUIET = 1'b0,
        RDR_FIRE  = 1'b1
    } rdr_e;

    function automatic hist_e hist_next(input hist_e cur, input logic taken);
        hist_e nxt;
        unique case (cur)
            HIST_STRONG_NT: nxt = taken ? HIST_WEAK_NT  : HIST_STRONG_NT;
            HIST_WEAK_NT:   nxt = taken ? HIST_WEAK_T   : HIST_STRONG_NT;
            HIST_WEAK_T:    nxt = taken ? HIST_STRONG_T : HIST_WEAK_NT;
            HIST_STRONG_T:  nxt = taken ? HIST_STRONG_T : HIST_WEAK_T;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bpred_btb.sv
module bpred_btb
    import bpred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-3:0] lk_wa,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_target,
    output hist_e             lk_hist,
    input  logic              up_en,
    input  logic [ADDR_W-3:0] up_wa,
    input  logic              up_cond,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    localparam int WA_W  = ADDR_W - 2;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = WA_W - IDX_W;

    logic              ent_vld [ENTRIES];
    logic [TAG_W-1:0]  ent_tag [ENTRIES];
    logic [ADDR_W-1:0] ent_tgt [ENTRIES];
    hist_e             ent_hist[ENTRIES];

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             up_hit;

    assign lk_idx = lk_wa[IDX_W-1:0];
    assign lk_tag = lk_wa[WA_W-1:IDX_W];
    assign up_idx = up_wa[IDX_W-1:0];
    assign up_tag = up_wa[WA_W-1:IDX_W];

    assign lk_hit    = ent_vld[lk_idx] && (ent_tag[lk_idx] == lk_tag);
    assign lk_target = ent_tgt[lk_idx];
    assign lk_hist   = ent_hist[lk_idx];
    assign up_hit    = ent_vld[up_idx] && (ent_tag[up_idx] == up_tag);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [ADDR_W-1:0] a_q;
        hist_e             h_q;
        logic              sel;

        assign sel = up_en && (up_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (sel && !up_hit && up_taken) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                if (up_hit) begin
                    if (up_cond) h_q <= hist_next(h_q, up_taken);
                    if (up_taken) a_q <= up_target;
                end else if (up_taken) begin
                    t_q <= up_tag;
                    a_q <= up_target;
                    h_q <= HIST_WEAK_T;
                end
            end
        end

        assign ent_vld[e]  = v_q;
        assign ent_tag[e]  = t_q;
        assign ent_tgt[e]  = a_q;
        assign ent_hist[e] = h_q;
    end

endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic              top_valid,
    output logic [ADDR_W-1:0] top_addr
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  top_ptr;

    assign top_ptr   = ptr_q - PTR_W'(1);
    assign top_valid = (cnt_q != '0);
    assign top_addr  = slot_q[top_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            ptr_q <= ptr_q + PTR_W'(1);
            if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && top_valid) begin
            ptr_q <= top_ptr;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (ptr_q == PTR_W'(s))) slot_q[s] <= push_addr;
        end
    end

endmodule

// File: rtl/bpred_top.sv
module bpred_top
    import bpred_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ENTRIES   = 16,
    parameter int RAS_DEPTH = 8,
    parameter int STEP      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btb_en,
    input  logic              ras_en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [1:0]        fetch_kind,
    input  logic [ADDR_W-1:0] fetch_static_tgt,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic [1:0]        res_kind,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_pred_taken,
    input  logic [ADDR_W-1:0] res_pred_target,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc
);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(STEP);

    br_kind_e          f_kind, r_kind;
    logic [ADDR_W-1:0] f_fall;
    logic              lk_hit;
    logic [ADDR_W-1:0] lk_target;
    hist_e             lk_hist;
    logic              ras_push, ras_pop, ras_valid;
    logic [ADDR_W-1:0] ras_top;
    logic              mispredict;
    logic [ADDR_W-1:0] correct_pc;
    rdr_e              rdr_q, rdr_d;
    logic [ADDR_W-1:0] rdr_pc_q;

    assign f_kind = br_kind_e'(fetch_kind);
    assign r_kind = br_kind_e'(res_kind);
    assign f_fall = fetch_pc + STEP_W;

    bpred_btb #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_wa     (fetch_pc[ADDR_W-1:2]),
        .lk_hit    (lk_hit),
        .lk_target (lk_target),
        .lk_hist   (lk_hist),
        .up_en     (res_valid && (r_kind != BR_RET)),
        .up_wa     (res_pc[ADDR_W-1:2]),
        .up_cond   (r_kind == BR_COND),
        .up_taken  (res_taken),
        .up_target (res_target)
    );

    bpred_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ras_push),
        .push_addr (f_fall),
        .pop       (ras_pop),
        .top_valid (ras_valid),
        .top_addr  (ras_top)
    );

    always_comb begin
        pred_taken  = 1'b0;
        pred_target = f_fall;
        ras_push    = fetch_valid && ras_en && (f_kind == BR_CALL);
        ras_pop     = fetch_valid && ras_en && (f_kind == BR_RET) && ras_valid;
        if (fetch_valid && btb_en) begin
            unique case (f_kind)
                BR_JUMP, BR_CALL: begin
                    if (lk_hit) begin
                        pred_taken  = 1'b1;
                        pred_target = lk_target;
                    end
                end
                BR_COND: begin
                    if (lk_hit) begin
                        if (lk_hist inside {HIST_WEAK_T, HIST_STRONG_T}) begin
                            pred_taken  = 1'b1;
                            pred_target = lk_target;
                        end
                    end else if (fetch_static_tgt < fetch_pc) begin
                        pred_taken  = 1'b1;
                        pred_target = fetch_static_tgt;
                    end
                end
                BR_RET: begin
                    if (ras_en && ras_valid) begin
                        pred_taken  = 1'b1;
                        pred_target = ras_top;
                    end
                end
            endcase
        end
    end

    assign mispredict = (res_taken != res_pred_taken) ||
                        (res_taken && (res_target != res_pred_target));
    assign correct_pc = res_taken ? res_target : (res_pc + STEP_W);

    always_comb begin
        rdr_d = (res_valid && mispredict) ? RDR_FIRE : RDR_QUIET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdr_q    <= RDR_QUIET;
            rdr_pc_q <= '0;
        end else begin
            rdr_q <= rdr_d;
            if (rdr_d == RDR_FIRE) rdr_pc_q <= correct_pc;
        end
    end

    assign redirect    = (rdr_q == RDR_FIRE);
    assign redirect_pc = rdr_pc_q;

endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              btb_en,
    input logic              ras_en,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [1:0]        fetch_kind,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_target,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_pc,
    input logic              res_taken,
    input logic              redirect,
    input logic [ADDR_W-1:0] redirect_pc
);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(STEP);

    AST_OFF_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !btb_en) |-> (!pred_taken && pred_target == fetch_pc + STEP_W)); // R6

    AST_RET_NEEDS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_kind == 2'd3 && !ras_en) |-> !pred_taken); // R7

    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !pred_taken) |-> (pred_target == fetch_pc + STEP_W)); // R1

    AST_REDIRECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(res_valid)); // R8

    AST_REDIRECT_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !$past(res_taken)) |-> (redirect_pc == $past(res_pc) + STEP_W)); // R8

    AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> !redirect); // R8

endmodule

bind bpred_top bpred_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .btb_en      (btb_en),
    .ras_en      (ras_en),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .fetch_kind  (fetch_kind),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .res_valid   (res_valid),
    .res_pc      (res_pc),
    .res_taken   (res_taken),
    .redirect    (redirect),
    .redirect_pc (redirect_pc)
);

// File: tb/bpred_top_tb.sv
`timescale 1ns/1ps
module bpred_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btb_en = 1'b1, ras_en = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0, fetch_static_tgt = '0;
    logic [1:0]  fetch_kind = '0;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic        res_valid = 1'b0, res_taken = 1'b0, res_pred_taken = 1'b0;
    logic [31:0] res_pc = '0, res_target = '0, res_pred_target = '0;
    logic [1:0]  res_kind = '0;
    logic        redirect;
    logic [31:0] redirect_pc;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bpred_top u_dut (
        .clk(clk), .rst_n(rst_n), .btb_en(btb_en), .ras_en(ras_en),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_kind(fetch_kind),
        .fetch_static_tgt(fetch_static_tgt), .pred_taken(pred_taken),
        .pred_target(pred_target), .res_valid(res_valid), .res_pc(res_pc),
        .res_kind(res_kind), .res_taken(res_taken), .res_target(res_target),
        .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
        .redirect(redirect), .redirect_pc(redirect_pc)
    );

    // reference model state
    bit          m_vld [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_tgt [16];
    int          m_ctr [16];
    logic [31:0] m_stk [8];
    int          m_ptr, m_cnt;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < 16; i++) m_vld[i] = 0;
        m_ptr = 0;
        m_cnt = 0;
    endfunction

    function automatic void predict(output logic tk, output logic [31:0] tg);
        int idx;
        bit hit;
        idx = int'(fetch_pc[5:2]);
        hit = m_vld[idx] && (m_tag[idx] == fetch_pc[31:6]);
        tk = 1'b0;
        tg = fetch_pc + 32'd4;
        if (fetch_valid && btb_en) begin
            case (fetch_kind)
                2'd0, 2'd2: if (hit) begin tk = 1'b1; tg = m_tgt[idx]; end
                2'd1: begin
                    if (hit) begin
                        if (m_ctr[idx] >= 2) begin tk = 1'b1; tg = m_tgt[idx]; end
                    end else if (fetch_static_tgt < fetch_pc) begin
                        tk = 1'b1; tg = fetch_static_tgt;
                    end
                end
                default: if (ras_en && m_cnt > 0) begin tk = 1'b1; tg = m_stk[(m_ptr + 7) % 8]; end
            endcase
        end
    endfunction

    function automatic void model_update();
        int idx;
        bit hit;
        if (res_valid && res_kind != 2'd3) begin
            idx = int'(res_pc[5:2]);
            hit = m_vld[idx] && (m_tag[idx] == res_pc[31:6]);
            if (hit) begin
                if (res_kind == 2'd1) begin
                    if (res_taken && m_ctr[idx] < 3) m_ctr[idx]++;
                    if (!res_taken && m_ctr[idx] > 0) m_ctr[idx]--;
                end
                if (res_taken) m_tgt[idx] = res_target;
            end else if (res_taken) begin
                m_vld[idx] = 1; m_tag[idx] = res_pc[31:6];
                m_tgt[idx] = res_target; m_ctr[idx] = 2;
            end
        end
        if (fetch_valid && ras_en) begin
            if (fetch_kind == 2'd2) begin
                m_stk[m_ptr] = fetch_pc + 32'd4;
                m_ptr = (m_ptr + 1) % 8;
                if (m_cnt < 8) m_cnt++;
            end else if (fetch_kind == 2'd3 && m_cnt > 0) begin
                m_ptr = (m_ptr + 7) % 8;
                m_cnt--;
            end
        end
    endfunction

    // one cycle: inputs already driven at the falling edge
    task automatic tick(input string rq);
        logic        et;
        logic [31:0] etg;
        bit          mp;
        logic [31:0] ecor;
        #1;
        predict(et, etg);
        if (fetch_valid) begin
            chk({rq, " taken"}, {31'b0, pred_taken}, {31'b0, et});
            chk({rq, " target"}, pred_target, etg);
        end
        mp = (res_taken != res_pred_taken) || (res_taken && res_target != res_pred_target);
        ecor = res_taken ? res_target : res_pc + 32'd4;
        @(posedge clk);
        #1;
        model_update();
        chk("R8 redirect", {31'b0, redirect}, {31'b0, res_valid && mp});
        if (res_valid && mp) chk("R8 redirect_pc", redirect_pc, ecor);
        @(negedge clk);
    endtask

    task automatic idle_in();
        fetch_valid = 0; res_valid = 0;
    endtask

    task automatic fetch(input logic [1:0] k, input logic [31:0] pc, input logic [31:0] st, input string rq);
        idle_in();
        fetch_valid = 1; fetch_kind = k; fetch_pc = pc; fetch_static_tgt = st;
        tick(rq);
        idle_in();
    endtask

    task automatic resolve(input logic [1:0] k, input logic [31:0] pc, input logic tk,
                           input logic [31:0] tg, input logic ptk, input logic [31:0] ptg, input string rq);
        idle_in();
        res_valid = 1; res_kind = k; res_pc = pc; res_taken = tk; res_target = tg;
        res_pred_taken = ptk; res_pred_target = ptg;
        tick(rq);
        idle_in();
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    function automatic logic [31:0] pool_pc();
        return 32'h0000_4000 | ($urandom_range(0, 3) << 6) | ($urandom_range(0, 15) << 2);
    endfunction

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        model_clear();
        @(negedge clk);
        do_reset();

        // R12: reset state
        chk("R12 redirect low", {31'b0, redirect}, 32'd0);
        fetch(2'd0, 32'h0000_4010, 32'h0, "R12 empty buffer jump");
        fetch(2'd3, 32'h0000_4020, 32'h0, "R12 empty stack ret");

        // R1: jump allocation then hit; call miss
        resolve(2'd0, 32'h0000_4010, 1, 32'h0000_8000, 0, 32'h0, "R9 alloc jump");
        fetch(2'd0, 32'h0000_4010, 32'h0, "R1 jump hit");
        fetch(2'd2, 32'h0000_4030, 32'h0, "R1 call miss");
        fetch(2'd0, 32'h0000_4050, 32'h0, "R1 alias tag miss"); // same index, other tag

        // R2 / R9: history walk
        resolve(2'd1, 32'h0000_4100, 1, 32'h0000_9000, 0, 32'h0, "R9 alloc cond");
        fetch(2'd1, 32'h0000_4100, 32'hFFFF_0000, "R2 weak taken");
        resolve(2'd1, 32'h0000_4100, 0, 32'h0, 1, 32'h0000_9000, "R8 mispredict nt");
        fetch(2'd1, 32'h0000_4100, 32'h0, "R2 weak not taken");
        resolve(2'd1, 32'h0000_4100, 0, 32'h0, 0, 32'h0, "R8 correct nt");
        resolve(2'd1, 32'h0000_4100, 0, 32'h0, 0, 32'h0, "R9 saturate low");
        resolve(2'd1, 32'h0000_4100, 1, 32'h0000_9000, 0, 32'h0, "R9 step up");
        fetch(2'd1, 32'h0000_4100, 32'h0, "R9 saturated low then one up");
        resolve(2'd1, 32'h0000_4100, 1, 32'h0000_9000, 0, 32'h0, "R9 step up");
        fetch(2'd1, 32'h0000_4100, 32'h0, "R2 taken again");
        for (int i = 0; i < 3; i++) resolve(2'd1, 32'h0000_4100, 1, 32'h0000_9000, 1, 32'h0000_9000, "R9 saturate high");
        resolve(2'd1, 32'h0000_4100, 0, 32'h0, 1, 32'h0000_9000, "R9 one down");
        fetch(2'd1, 32'h0000_4100, 32'h0, "R9 still taken after one down");

        // R3: static guess on miss
        fetch(2'd1, 32'h0000_4204, 32'h0000_4000, "R3 backward taken");
        fetch(2'd1, 32'h0000_4204, 32'h0000_4300, "R3 forward not taken");

        // R5: returns never allocate
        resolve(2'd3, 32'h0000_4208, 1, 32'h0000_A000, 0, 32'h0, "R5 ret resolve");
        fetch(2'd0, 32'h0000_4208, 32'h0, "R5 no entry for ret");

        // R6: buffer disabled
        btb_en = 0;
        fetch(2'd0, 32'h0000_4010, 32'h0, "R6 disabled jump");
        fetch(2'd1, 32'h0000_4204, 32'h0000_4000, "R6 disabled cond");
        btb_en = 1;

        // R4 / R11: stack order
        do_reset();
        fetch(2'd2, 32'h0000_5000, 32'h0, "R4 call one");
        fetch(2'd2, 32'h0000_5100, 32'h0, "R4 call two");
        fetch(2'd3, 32'h0000_6000, 32'h0, "R4 pop newest");
        fetch(2'd3, 32'h0000_6000, 32'h0, "R4 pop older");
        fetch(2'd3, 32'h0000_6000, 32'h0, "R11 empty ret");

        // R7: stack disabled
        fetch(2'd2, 32'h0000_5200, 32'h0, "R7 push before disable");
        ras_en = 0;
        fetch(2'd2, 32'h0000_5300, 32'h0, "R7 call ignored");
        fetch(2'd3, 32'h0000_6000, 32'h0, "R7 ret not predicted");
        ras_en = 1;
        fetch(2'd3, 32'h0000_6000, 32'h0, "R7 stack untouched");

        // R10: wrap
        for (int i = 0; i < 9; i++) fetch(2'd2, 32'h0000_7000 + 32'(i * 16), 32'h0, "R10 push");
        for (int i = 0; i < 8; i++) fetch(2'd3, 32'h0000_6000, 32'h0, "R10 pop");
        fetch(2'd3, 32'h0000_6000, 32'h0, "R10 empty after wrap");

        // random mix, R1 R2 R3 R4 R8 R9
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            btb_en           = ($urandom_range(0, 9) != 0);
            ras_en           = ($urandom_range(0, 9) != 0);
            fetch_valid      = $urandom_range(0, 1);
            fetch_kind       = 2'($urandom_range(0, 3));
            fetch_pc         = pool_pc();
            fetch_static_tgt = pool_pc();
            res_valid        = $urandom_range(0, 1);
            res_kind         = 2'($urandom_range(0, 3));
            res_pc           = pool_pc();
            res_taken        = $urandom_range(0, 1);
            res_target       = pool_pc();
            res_pred_taken   = $urandom_range(0, 1);
            res_pred_target  = $urandom_range(0, 1) ? res_target : pool_pc();
            tick("R1 R2 R3 R4 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule